// File: doc/BRIEF.md
# Grouped GPIO Interrupt Summary with End-of-Interrupt and Status Blocking

This block sits between the per-pin interrupt logic of a GPIO bank and the system interrupt controller. Every pin supplies a pending flag; the block folds the flags of four consecutive pins into one summary bit. The 46 summary bits are kept in a register and read through two 32-bit words. Any set summary bit raises one shared interrupt line.

Software ends a service pass by writing an end-of-interrupt action bit in a master control word. The line then drops for one cycle and comes back at once if work is still pending. The master word also holds a status-blocking enable and a 12-bit window length. While blocking is enabled, a write to any pin's debounce setting opens a window that lasts that many reference-clock ticks. During the window, summary capture is frozen and every pin's interrupt-enable bit reads back as 0.

The register interface is a plain write strobe with a combinational read, both selected by a 2-bit address.

Top module: `pin_irq_summary`

## Requirements
- R1: Summary bit n equals the OR of the pending flags of pins 4n to 4n+3. It is registered, so it appears one clock after the pins change.
- R2: Address 0 reads summary bits 31:0. Address 1 reads summary bits 45:32 in its bits 13:0, with bits 31:14 reading 0. Address 3 reads 0.
- R3: Address 2 is the master word: bits 11:0 hold the window length and bit 12 holds the blocking enable. A write stores both fields, and both read back.
- R4: `irq_out` is a register. It is high in the cycle after the summary is non-zero and low in the cycle after the summary is zero.
- R5: A write to address 2 with bit 13 set is an end-of-interrupt. `irq_out` is low in the next cycle and is high again one cycle later if the summary is still non-zero. Bit 13 always reads 0.
- R6: A `dbnc_wr` pulse while the blocking enable is set loads the window counter with the length. The counter then drops by one on each `ref_tick`, and the window is active while it is non-zero. With the enable clear, the pulse has no effect. Bit 14 of address 2 and the `blocking` port show whether the window is active.
- R7: While the window is active, the summary register holds its value whatever the pins do.
- R8: `pin_irq_en_view` equals `pin_irq_en` outside the window and is all 0 inside it.
- R9: A `dbnc_wr` pulse during an active window restarts the window at the full length. A pulse with a length of 0 opens no window.
- R10: Synchronous reset clears the summary, the master word, the window counter and `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_pending | input | 184 | Pending flag of each pin |
| pin_irq_en | input | 184 | Stored interrupt-enable bit of each pin |
| ref_tick | input | 1 | One-cycle pulse per reference-clock tick |
| dbnc_wr | input | 1 | Pulse: some pin's debounce setting was written |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Shared interrupt line |
| blocking | output | 1 | Status-blocking window active |
| pin_irq_en_view | output | 184 | Enable bits as software sees them |

## Verification
The assertions assume that `dbnc_wr`, `ref_tick` and `reg_wr` are single-cycle-qualified strobes sampled on the clock edge. They also assume that the pending flags are synchronous to `clk`, so a frozen summary really is stable for a full cycle. The stimulus drives every input only on falling edges. Ticks come from a fixed divider, and debounce pulses and register writes last exactly one cycle. Pin patterns change freely, including during a blocking window, so the freeze is exercised against moving inputs.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        RA_SUM_LO = 2'd0,
        RA_SUM_HI = 2'd1,
        RA_MASTER = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             en;
        reg_addr_e        addr;
        logic [WORD_W-1:0] data;
    } bus_wr_t;

endpackage

// File: rtl/pin_group_reduce.sv
module pin_group_reduce #(
    parameter int NUM_GROUPS = 46,
    parameter int GROUP_SIZE = 4
) (
    input  logic [NUM_GROUPS*GROUP_SIZE-1:0] pend,
    output logic [NUM_GROUPS-1:0]            grp
);
    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            assign grp[g] = |pend[g*GROUP_SIZE +: GROUP_SIZE];
        end
    endgenerate
endmodule

// File: rtl/blk_window_timer.sv
module blk_window_timer #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             active
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= len;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R6: the window never opens without a start pulse
    p_no_spont_open_r6: assert property (@(posedge clk) disable iff (rst)
        (!active && !start) |=> !active);

    // R9: a start pulse loads the length, so activity next cycle follows it
    p_restart_len_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (active == ($past(len) != '0)));
endmodule

// File: rtl/eoi_line_ctl.sv
module eoi_line_ctl (
    input  logic clk,
    input  logic rst,
    input  logic any_set,
    input  logic eoi,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= any_set && !eoi;
    end

    // R5: end-of-interrupt drops the line in the following cycle
    p_eoi_drop_r5: assert property (@(posedge clk) disable iff (rst)
        eoi |=> !irq);

    // R4: a non-zero summary without EOI raises the line
    p_irq_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (any_set && !eoi) |=> irq);

    // R4: an empty summary leaves the line low
    p_irq_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !any_set |=> !irq);
endmodule

// File: rtl/pin_irq_summary.sv
module pin_irq_summary
    import pin_irq_pkg::*;
#(
    parameter int NUM_GROUPS = 46,
    parameter int GROUP_SIZE = 4,
    parameter int LEN_W      = 12
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_GROUPS*GROUP_SIZE-1:0]    pin_pending,
    input  logic [NUM_GROUPS*GROUP_SIZE-1:0]    pin_irq_en,
    input  logic                                ref_tick,
    input  logic                                dbnc_wr,
    input  logic                                reg_wr,
    input  logic [1:0]                          reg_addr,
    input  logic [31:0]                         reg_wdata,
    output logic [31:0]                         reg_rdata,
    output logic                                irq_out,
    output logic                                blocking,
    output logic [NUM_GROUPS*GROUP_SIZE-1:0]    pin_irq_en_view
);
    localparam int NUM_PINS = NUM_GROUPS * GROUP_SIZE;
    localparam int WIDE_W   = 2 * WORD_W;
    localparam int MASK_BIT = LEN_W;
    localparam int EOI_BIT  = LEN_W + 1;
    localparam int BUSY_BIT = LEN_W + 2;

    bus_wr_t               wr;
    logic [NUM_GROUPS-1:0] grp_now;
    logic [NUM_GROUPS-1:0] sum_q;
    logic [WIDE_W-1:0]     sum_wide;
    logic [LEN_W-1:0]      len_q;
    logic                  mask_q;
    logic                  master_wr;
    logic                  eoi;
    logic                  win_start;

    assign wr.en   = reg_wr;
    assign wr.addr = reg_addr_e'(reg_addr);
    assign wr.data = reg_wdata;

    assign master_wr = wr.en && (wr.addr == RA_MASTER);
    assign eoi       = master_wr && wr.data[EOI_BIT];
    assign win_start = dbnc_wr && mask_q;

    pin_group_reduce #(.NUM_GROUPS(NUM_GROUPS), .GROUP_SIZE(GROUP_SIZE)) u_reduce (
        .pend (pin_pending),
        .grp  (grp_now)
    );

    blk_window_timer #(.LEN_W(LEN_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (ref_tick),
        .start  (win_start),
        .len    (len_q),
        .active (blocking)
    );

    eoi_line_ctl u_line (
        .clk     (clk),
        .rst     (rst),
        .any_set (|sum_q),
        .eoi     (eoi),
        .irq     (irq_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sum_q <= '0;
        else if (!blocking)
            sum_q <= grp_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            mask_q <= 1'b0;
        end else if (master_wr) begin
            len_q  <= wr.data[LEN_W-1:0];
            mask_q <= wr.data[MASK_BIT];
        end
    end

    assign sum_wide        = {{(WIDE_W-NUM_GROUPS){1'b0}}, sum_q};
    assign pin_irq_en_view = blocking ? {NUM_PINS{1'b0}} : pin_irq_en;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_SUM_LO: reg_rdata = sum_wide[WORD_W-1:0];
            RA_SUM_HI: reg_rdata = sum_wide[WIDE_W-1:WORD_W];
            RA_MASTER: begin
                reg_rdata[LEN_W-1:0] = len_q;
                reg_rdata[MASK_BIT]  = mask_q;
                reg_rdata[BUSY_BIT]  = blocking;
            end
            default:   reg_rdata = '0;
        endcase
    end

    // R7: summary frozen across an active window
    p_hold_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        blocking |=> $stable(sum_q));

    // R3: master fields change only on a master write
    p_master_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !master_wr |=> ($stable(len_q) && $stable(mask_q)));
endmodule

// File: tb/sim_pin_irq_summary.sv
module sim_pin_irq_summary;
    localparam int NG = 46;
    localparam int NP = NG * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_pending = '0;
    logic [NP-1:0] pin_irq_en = '0;
    logic          ref_tick = 1'b0;
    logic          dbnc_wr = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out;
    logic          blocking;
    logic [NP-1:0] pin_irq_en_view;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    pin_irq_summary u0 (
        .clk(clk), .rst(rst), .pin_pending(pin_pending), .pin_irq_en(pin_irq_en),
        .ref_tick(ref_tick), .dbnc_wr(dbnc_wr), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
        .blocking(blocking), .pin_irq_en_view(pin_irq_en_view)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model state
    logic [NG-1:0] m_sum = '0;
    logic          m_irq = 0;
    int            m_cnt = 0;
    int            m_len = 0;
    bit            m_mask = 0;

    function automatic logic [NG-1:0] fold(input logic [NP-1:0] p);
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++) r[g] = p[4*g] | p[4*g+1] | p[4*g+2] | p[4*g+3];
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        logic [63:0] w;
        w = {18'd0, m_sum};
        case (a)
            2'd0: return w[31:0];
            2'd1: return w[63:32];
            2'd2: return {17'd0, (m_cnt != 0), 1'b0, m_mask, m_len[11:0]};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic          eoi;
        logic          n_irq;
        logic [NG-1:0] n_sum;
        int            n_cnt;
        cyc++;
        if (rst) begin
            m_sum = '0; m_irq = 0; m_cnt = 0; m_len = 0; m_mask = 0;
        end else begin
            eoi   = reg_wr && reg_addr == 2'd2 && reg_wdata[13];
            n_irq = (m_sum != '0) && !eoi;
            n_sum = (m_cnt != 0) ? m_sum : fold(pin_pending);
            n_cnt = m_cnt;
            if (dbnc_wr && m_mask) n_cnt = m_len;
            else if (ref_tick && m_cnt != 0) n_cnt = m_cnt - 1;
            if (reg_wr && reg_addr == 2'd2) begin
                m_len  = int'(reg_wdata[11:0]);
                m_mask = reg_wdata[12];
            end
            m_irq = n_irq; m_sum = n_sum; m_cnt = n_cnt;
        end
        #1;
        chk("R4/R5 irq_out", NP'(irq_out), NP'(m_irq));
        chk("R6/R9 blocking", NP'(blocking), NP'(m_cnt != 0));
        chk("R1/R2/R3 reg_rdata", NP'(reg_rdata), NP'(m_read(reg_addr)));
        chk("R8 enable view", pin_irq_en_view, (m_cnt != 0) ? '0 : pin_irq_en);
    end

    always @(negedge clk) ref_tick <= (cyc % 3 == 0);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, NP'(reg_rdata), NP'(exp));
    endtask

    task automatic dbnc_pulse();
        @(negedge clk);
        dbnc_wr = 1;
        @(negedge clk);
        dbnc_wr = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        // R10 reset state
        chk("R10 irq after reset", NP'(irq_out), '0);
        chk("R10 blocking after reset", NP'(blocking), '0);
        rd_chk("R10 low word", 2'd0, 0);
        rd_chk("R10 master word", 2'd2, 0);

        // R1 single pin in group 1
        pin_pending = '0; pin_pending[5] = 1'b1;
        step(3);
        rd_chk("R1 pin5 -> bit1", 2'd0, 32'h2);
        chk("R4 irq high", NP'(irq_out), NP'(1));
        for (int k = 0; k < 4; k++) begin
            pin_pending = '0; pin_pending[4*7+k] = 1'b1;
            step(2);
            rd_chk("R1 group7 member", 2'd0, 32'h80);
        end
        // R2 top group
        pin_pending = '0; pin_pending[183] = 1'b1;
        step(2);
        rd_chk("R2 group45 high word", 2'd1, 32'h2000);
        rd_chk("R2 low word empty", 2'd0, 0);
        pin_pending = '1;
        step(2);
        rd_chk("R2 high word all", 2'd1, 32'h3FFF);
        rd_chk("R2 low word all", 2'd0, 32'hFFFF_FFFF);
        rd_chk("R2 spare address", 2'd3, 0);

        // R5 EOI with work still pending
        step(1);
        wr_reg(2'd2, 32'h2000);
        chk("R5 irq low after EOI", NP'(irq_out), '0);
        step(1);
        chk("R5 irq back after EOI", NP'(irq_out), NP'(1));
        rd_chk("R5 EOI reads 0", 2'd2, 0);
        pin_pending = '0;
        step(2);
        wr_reg(2'd2, 32'h2000);
        step(2);
        chk("R4 irq stays low", NP'(irq_out), '0);

        // random patterns
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            pin_pending = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}
                        & {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            reg_addr = 2'(i % 4);
        end

        // R6 debounce write with blocking disabled
        pin_irq_en = '1;
        wr_reg(2'd2, 32'h0005);
        rd_chk("R3 length readback", 2'd2, 32'h0005);
        dbnc_pulse();
        chk("R6 no window when disabled", NP'(blocking), '0);

        // R6/R7/R8 window
        wr_reg(2'd2, 32'h1005);
        rd_chk("R3 enable readback", 2'd2, 32'h1005);
        pin_pending = '0; pin_pending[0] = 1'b1;
        step(2);
        dbnc_pulse();
        chk("R6 window open", NP'(blocking), NP'(1));
        chk("R8 view zero", pin_irq_en_view, '0);
        pin_pending = '0; pin_pending[8] = 1'b1;
        step(2);
        rd_chk("R7 summary frozen", 2'd0, 32'h1);
        rd_chk("R6 busy bit", 2'd2, 32'h5005);
        // R9 restart mid-window
        dbnc_pulse();
        step(30);
        chk("R6 window closed", NP'(blocking), '0);
        rd_chk("R7 summary resumes", 2'd0, 32'h4);
        chk("R8 view restored", pin_irq_en_view, '1);
        // R9 zero length
        wr_reg(2'd2, 32'h1000);
        dbnc_pulse();
        chk("R9 zero length no window", NP'(blocking), '0);

        // windows under random activity
        wr_reg(2'd2, 32'h1007);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            pin_pending = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}
                        & {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            pin_irq_en  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            dbnc_wr = (i % 17 == 3);
            reg_addr = 2'(i % 3);
        end
        dbnc_wr = 0;
        // reset mid-operation
        @(negedge clk); rst = 1;
        step(2); rst = 0;
        step(1);
        rd_chk("R10 master cleared", 2'd2, 0);
        step(3);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(4 * 150000);
                n_chk++; n_err++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule